// File: doc/BRIEF.md
# Iterative Multiply and Multiply-Accumulate Unit

This block computes integer products for a processor datapath. A single start strobe captures two W-bit multiplicands, a W-bit addend, a 2W-bit accumulator (given as high and low words), an operation code and a set-flags request. A shift-and-add engine then retires DIGIT bits of the second multiplicand on each clock. After the last step, a one-cycle done pulse presents the result, write-enables for one or two destination registers, and negative and zero flags. The flags carry their own write-enable.

Four operations share the one engine. The short forms return the low W bits of either a×b or a×b+addend; any carry beyond W bits is lost. The long forms return the full unsigned 2W-bit product, either on its own or added to the accumulator pair with wrap-around modulo 2^(2W). Results are written as a low word and a high word. The number of steps is W/DIGIT, so the latency can be traded against adder width through a parameter.

Top module: `mac_unit`

## Requirements
- R1: After reset, done, wr_lo, wr_hi and flag_we are 0, and res_lo and res_hi are 0.
- R2: Operation code 2'b00 gives res_lo = low W bits of op_a×op_b, with res_hi = 0, wr_lo = 1 and wr_hi = 0 during done.
- R3: Operation code 2'b01 gives res_lo = low W bits of op_a×op_b+addend, with res_hi = 0, wr_lo = 1 and wr_hi = 0 during done.
- R4: Operation code 2'b10 gives {res_hi,res_lo} = the unsigned 2W-bit product op_a×op_b, with wr_lo = wr_hi = 1 during done.
- R5: Operation code 2'b11 gives {res_hi,res_lo} = ({acc_hi,acc_lo} + op_a×op_b) mod 2^(2W), with wr_lo = wr_hi = 1 during done.
- R6: done is high for exactly one cycle. It rises on the W/DIGIT-th rising edge after the edge that samples start (the 4th edge with the defaults). Results are valid in that cycle.
- R7: flag_we equals done AND the set_flags value that was sampled with start. For short forms, flag_n = res_lo bit W-1 and flag_z = 1 exactly when res_lo is zero.
- R8: For long forms, flag_n = res_hi bit W-1, and flag_z = 1 only when all 2W result bits are zero.
- R9: A start while an operation is in flight is ignored. The running operation finishes with its captured operands and produces exactly one done pulse.
- R10: res_lo and res_hi hold their values from the done cycle until the next accepted start, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches an operation when idle |
| op | input | 2 | Operation code (00 mul, 01 mul+add, 10 long mul, 11 long mul+acc) |
| set_flags | input | 1 | Request flag update for this operation |
| op_a | input | W | First multiplicand |
| op_b | input | W | Second multiplicand |
| addend | input | W | Addend for the short accumulate form |
| acc_lo | input | W | Accumulator low word for the long accumulate form |
| acc_hi | input | W | Accumulator high word for the long accumulate form |
| res_lo | output | W | Result low word |
| res_hi | output | W | Result high word (zero for short forms) |
| wr_lo | output | 1 | Write-enable for the low destination, valid with done |
| wr_hi | output | 1 | Write-enable for the high destination, valid with done |
| done | output | 1 | One-cycle completion pulse |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_we | output | 1 | Flag write-enable |

## Verification
The bench goes after all-ones operands in every form. A design that dropped the top partial products or the carry between digits would get 0xFFFFFFFE_00000001 wrong. A design that kept short-form overflow would put bits in res_hi. It also drives accumulator and addend values that wrap exactly to zero; a design that tested only the low word for zero, or let the carry escape, would report the wrong Z flag or a nonzero result. Operands are changed immediately after start, and a second start is injected mid-operation, to expose designs that read live inputs or restart. Latency is counted edge by edge against the step count.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef enum logic [1:0] {
      OP_MUL     = 2'b00,
      OP_MULADD  = 2'b01,
      OP_LMUL    = 2'b10,
      OP_LMULACC = 2'b11
   } mac_op_e;

   function automatic logic op_is_long(input mac_op_e o);
      return o[1];
   endfunction

   function automatic logic op_has_add(input mac_op_e o);
      return o[0];
   endfunction
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl #(
   parameter int STEPS = 4,
   localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic load,
   output logic step,
   output logic busy,
   output logic done
);
   logic [CW-1:0] count;
   logic          last;

   initial begin
      assert (STEPS >= 1) else $fatal(1, "STEPS must be at least 1");
   end

   assign last = (count == CW'(STEPS - 1));
   assign load = start && !busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         count <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy  <= 1'b1;
            count <= '0;
         end else if (busy) begin
            if (last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               count <= count + 1'b1;
            end
         end
      end
   end

   // R6: completion is a single-cycle pulse
   a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R6: the step counter never leaves its range
   a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(count) < STEPS));
   // R9: while busy, the counter advances by one each edge until the last step
   a_r9_count_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !last) |=> (busy && count == $past(count) + 1'b1));
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath
   import mac_pkg::*;
#(
   parameter int W     = 32,
   parameter int DIGIT = 8,
   localparam int AW   = 2 * W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  mac_op_e       op,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  op_b,
   input  logic [W-1:0]  addend,
   input  logic [W-1:0]  acc_lo,
   input  logic [W-1:0]  acc_hi,
   output logic [AW-1:0] acc
);
   logic [AW-1:0] a_sh;
   logic [W-1:0]  b_sh;
   logic [AW-1:0] partial;
   logic [AW-1:0] init_val;

   initial begin
      assert (W % DIGIT == 0) else $fatal(1, "W must be a multiple of DIGIT");
      assert (DIGIT >= 1 && DIGIT <= W) else $fatal(1, "DIGIT out of range");
   end

   always_comb begin
      unique case (op)
         OP_MULADD:  init_val = {{W{1'b0}}, addend};
         OP_LMULACC: init_val = {acc_hi, acc_lo};
         default:    init_val = '0;
      endcase
   end

   generate
      if (DIGIT == 1) begin : g_gate
         assign partial = b_sh[0] ? a_sh : '0;
      end else begin : g_mult
         logic [AW+DIGIT-1:0] wide;
         assign wide    = a_sh * {{(AW-DIGIT){1'b0}}, b_sh[DIGIT-1:0]};
         assign partial = wide[AW-1:0];
      end
   endgenerate

   generate
      if (DIGIT == W) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_sh <= '0;
               b_sh <= '0;
               acc  <= '0;
            end else if (load) begin
               a_sh <= {{W{1'b0}}, op_a};
               b_sh <= op_b;
               acc  <= init_val;
            end else if (step) begin
               acc  <= acc + partial;
            end
         end
      end else begin : g_iter
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               a_sh <= '0;
               b_sh <= '0;
               acc  <= '0;
            end else if (load) begin
               a_sh <= {{W{1'b0}}, op_a};
               b_sh <= op_b;
               acc  <= init_val;
            end else if (step) begin
               acc  <= acc + partial;
               a_sh <= a_sh << DIGIT;
               b_sh <= b_sh >> DIGIT;
            end
         end
      end
   endgenerate

   // R10: the accumulator only moves on a load or a step
   a_r10_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !step) |=> $stable(acc));
endmodule

// File: rtl/mac_flags.sv
module mac_flags #(
   parameter int W = 32
) (
   input  logic [W-1:0] lo,
   input  logic [W-1:0] hi,
   input  logic         is_long,
   output logic         neg,
   output logic         zero
);
   generate
      if (W > 1) begin : g_flags
         always_comb begin
            if (is_long) begin
               neg  = hi[W-1];
               zero = (lo == '0) && (hi == '0);
            end else begin
               neg  = lo[W-1];
               zero = (lo == '0);
            end
         end
      end else begin : g_tiny
         assign neg  = is_long ? hi[0] : lo[0];
         assign zero = is_long ? !(lo[0] | hi[0]) : !lo[0];
      end
   endgenerate
endmodule

// File: rtl/mac_unit.sv
module mac_unit
   import mac_pkg::*;
#(
   parameter int W     = 32,
   parameter int DIGIT = 8,
   localparam int STEPS = W / DIGIT,
   localparam int AW    = 2 * W
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [1:0]   op,
   input  logic         set_flags,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [W-1:0] addend,
   input  logic [W-1:0] acc_lo,
   input  logic [W-1:0] acc_hi,
   output logic [W-1:0] res_lo,
   output logic [W-1:0] res_hi,
   output logic         wr_lo,
   output logic         wr_hi,
   output logic         done,
   output logic         flag_n,
   output logic         flag_z,
   output logic         flag_we
);
   logic          load, step, busy;
   logic [AW-1:0] acc;
   mac_op_e       op_in, op_q;
   logic          sf_q;
   logic          is_long;

   initial begin
      assert (W >= 2) else $fatal(1, "W must be at least 2");
   end

   assign op_in = mac_op_e'(op);

   mac_ctrl #(.STEPS(STEPS)) ctrl_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .load(load), .step(step), .busy(busy), .done(done)
   );

   mac_datapath #(.W(W), .DIGIT(DIGIT)) dp_i (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step), .op(op_in),
      .op_a(op_a), .op_b(op_b), .addend(addend),
      .acc_lo(acc_lo), .acc_hi(acc_hi), .acc(acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q <= OP_MUL;
         sf_q <= 1'b0;
      end else if (load) begin
         op_q <= op_in;
         sf_q <= set_flags;
      end
   end

   assign is_long = op_is_long(op_q);
   assign res_lo  = acc[W-1:0];
   assign res_hi  = is_long ? acc[AW-1:W] : '0;
   assign wr_lo   = done;
   assign wr_hi   = done && is_long;
   assign flag_we = done && sf_q;

   mac_flags #(.W(W)) flags_i (
      .lo(res_lo), .hi(res_hi), .is_long(is_long),
      .neg(flag_n), .zero(flag_z)
   );

   // R7: flags are written only on completion
   a_r7_flag_we_done: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> done);
   // R8: a zero flag written means the whole result is zero
   a_r8_zero_means_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && flag_z) |-> (res_lo == '0 && res_hi == '0));
   // R9: the captured operation stays fixed while the engine runs
   a_r9_op_held: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(op_q));
   // R2: short forms never drive the high word
   a_r2_short_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !wr_hi) |-> (res_hi == '0));
endmodule

// File: tb/mac_unit_tb_top.sv
module mac_unit_tb_top;
   localparam int  W       = 32;
   localparam int  DIGIT   = 8;
   localparam int  STEPS   = W / DIGIT;
   localparam time CLK_PER = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [1:0]   op = 2'b00;
   logic         set_flags = 1'b0;
   logic [W-1:0] op_a = '0, op_b = '0, addend = '0, acc_lo = '0, acc_hi = '0;
   logic [W-1:0] res_lo, res_hi;
   logic         wr_lo, wr_hi, done, flag_n, flag_z, flag_we;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PER/2) clk = ~clk;

   mac_unit #(.W(W), .DIGIT(DIGIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .set_flags(set_flags),
      .op_a(op_a), .op_b(op_b), .addend(addend), .acc_lo(acc_lo), .acc_hi(acc_hi),
      .res_lo(res_lo), .res_hi(res_hi), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .done(done), .flag_n(flag_n), .flag_z(flag_z), .flag_we(flag_we)
   );

   task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] ref_result(input logic [1:0] o, input logic [W-1:0] a,
         input logic [W-1:0] b, input logic [W-1:0] ad, input logic [W-1:0] lo, input logic [W-1:0] hi);
      logic [127:0] full;
      full = 128'(a) * 128'(b);
      case (o)
         2'b00: return {32'h0, full[31:0]};
         2'b01: begin full = full + 128'(ad); return {32'h0, full[31:0]}; end
         2'b10: return full[63:0];
         default: begin full = full + {64'h0, hi, lo}; return full[63:0]; end
      endcase
   endfunction

   // Launch, scramble inputs, optionally inject a busy start, then check everything at done.
   task automatic run_op(input string req, input logic [1:0] o, input logic sf,
         input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] ad,
         input logic [W-1:0] lo, input logic [W-1:0] hi, input bit inject);
      logic [63:0] exp;
      logic        exp_n, exp_z;
      int          k;
      exp = ref_result(o, a, b, ad, lo, hi);
      @(negedge clk);
      op = o; set_flags = sf; op_a = a; op_b = b; addend = ad; acc_lo = lo; acc_hi = hi;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      op = ~o; set_flags = ~sf; op_a = ~a; op_b = b ^ 32'h5A5A_A5A5;
      addend = ~ad; acc_lo = ~lo; acc_hi = ~hi;
      k = 0;
      while (k < STEPS + 3) begin
         @(negedge clk);
         k++;
         if (inject && k == 2) start = 1'b1;
         else start = 1'b0;
         if (done) break;
      end
      start = 1'b0;
      check({req, " R6 latency"}, 128'(k), 128'(STEPS));
      check({req, " result"}, {64'h0, res_hi, res_lo}, {64'h0, exp});
      check({req, " write enables"}, {126'h0, wr_lo, wr_hi}, {126'h0, 1'b1, o[1]});
      if (o[1]) begin exp_n = exp[63]; exp_z = (exp == 64'h0); end
      else begin exp_n = exp[31]; exp_z = (exp[31:0] == 32'h0); end
      check({req, " R7 flag_we"}, 128'(flag_we), 128'(sf));
      if (sf) check({req, o[1] ? " R8 flags" : " R7 flags"},
                    {126'h0, flag_n, flag_z}, {126'h0, exp_n, exp_z});
      @(negedge clk);
      check({req, " R6 single pulse"}, 128'(done), 128'(0));
      if (inject) begin
         for (int j = 0; j < STEPS + 2; j++) begin
            @(negedge clk);
            check({req, " R9 no second done"}, 128'(done), 128'(0));
         end
         check({req, " R9 result kept"}, {64'h0, res_hi, res_lo}, {64'h0, exp});
      end
   endtask

   initial begin
      int unsigned seed;
      logic [63:0] held;
      seed = 32'd12345;
      void'($urandom(seed));

      #(CLK_PER * 3);
      @(negedge clk);
      check("R1 reset outputs", {59'h0, done, wr_lo, wr_hi, flag_we, res_lo, res_hi},
            128'h0);
      rst_n = 1'b1;

      run_op("R2 mul small", 2'b00, 1'b1, 32'd1234, 32'd5678, 32'd0, 32'd0, 32'd0, 1'b0);
      run_op("R2 mul all-ones", 2'b00, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd7, 32'd9, 32'd3, 1'b0);
      run_op("R7 short negative", 2'b00, 1'b1, 32'h8000_0000, 32'd1, 32'd0, 32'd0, 32'd0, 1'b0);
      run_op("R3 muladd wrap to zero", 2'b01, 1'b1, 32'hFFFF_FFFF, 32'd1, 32'd1, 32'd0, 32'd0, 1'b0);
      run_op("R3 muladd", 2'b01, 1'b0, 32'd1000, 32'd3000, 32'd77, 32'd0, 32'd0, 1'b0);
      run_op("R4 long all-ones", 2'b10, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd0, 32'd0, 1'b0);
      run_op("R8 long low zero only", 2'b10, 1'b1, 32'h0001_0000, 32'h0001_0000, 32'd0, 32'd0, 32'd0, 1'b0);
      run_op("R8 long zero", 2'b10, 1'b1, 32'd0, 32'hDEAD_BEEF, 32'd0, 32'd0, 32'd0, 1'b0);
      run_op("R5 long acc wrap", 2'b11, 1'b1, 32'd1, 32'd1, 32'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op("R5 long acc all-ones", 2'b11, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0,
             32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);
      run_op("R9 busy start", 2'b11, 1'b1, 32'h1234_5678, 32'h9ABC_DEF0, 32'd0,
             32'h1111_2222, 32'h3333_4444, 1'b1);

      held = {res_hi, res_lo};
      for (int j = 0; j < 5; j++) begin
         @(negedge clk);
         op_a = $urandom; op_b = $urandom; acc_lo = $urandom; acc_hi = $urandom;
      end
      check("R10 result hold", {64'h0, res_hi, res_lo}, {64'h0, held});

      for (int i = 0; i < 40; i++) begin
         logic [1:0] ro;
         ro = 2'($urandom % 4);
         run_op("R2 R3 R4 R5 random", ro, 1'($urandom % 2), $urandom, $urandom,
                $urandom, $urandom, $urandom, 1'b0);
      end

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PER * 20000);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule